// File: doc/BRIEF.md
# Infrared Clicker Packet Transmitter

This block turns a single key action on a classroom response handset into the chip stream that drives its infrared LED. When a key is pressed, the block captures the 4-bit key code and the 24-bit handset identifier. It appends an 8-bit checksum, giving a 36-bit word. Each bit of the word goes out as three chips of equal length.

The word is sent in two bursts. The second burst repeats all 36 bits with every bit inverted. A dark gap of fixed length separates the two bursts. Timing is derived from a chip-rate clock-enable pulse (`chip_tick`). A chip lasts `CHIP_TICKS` tick intervals and the gap lasts `GAP_TICKS` tick intervals.

Letter keys transmit on the press strobe. The star key transmits on the release strobe. The `busy` output tells the surrounding logic when a new key action would be dropped.

Top module: `ir_clicker_tx`

## Requirements
- R1: After reset and whenever `busy` is low, `ir_out` is 0 and `busy` is 0.
- R2: The 36-bit word is sent most significant bit first. It is the key code in bits 35..32, the identifier in bits 31..8 and the checksum in bits 7..0.
- R3: The checksum is the 4-bit key code plus the three identifier bytes, modulo 256 (carry discarded). Key 1001 with identifier 0x00D915 gives 0xF7, and key 1100 with identifier 0xABCDEF gives 0x73.
- R4: Each bit is three chips of `CHIP_TICKS` tick intervals each, in the order 0, 1, then the data value. The first chip begins at the first `chip_tick` after the cycle the key action is accepted, and every chip change happens on a `chip_tick` cycle.
- R5: The second burst carries the bitwise inverse of all 36 bits of the first, using the same chip coding.
- R6: Between the last chip of the first burst and the first chip of the second, `ir_out` stays 0 for exactly `GAP_TICKS` tick intervals.
- R7: With `key_star` = 0, a `press_stb` while idle starts a transmission, and a `release_stb` has no effect.
- R8: With `key_star` = 1, a `release_stb` while idle starts a transmission, and a `press_stb` has no effect.
- R9: `busy` rises the cycle after acceptance and falls at the `chip_tick` that ends the last chip of the second burst. Strobes that arrive while `busy` is high are ignored and do not alter the word in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_tick | input | 1 | Chip-rate clock enable, one cycle wide |
| btn_code | input | 4 | Key code, leading 1 |
| tx_id | input | 24 | Handset identifier |
| key_star | input | 1 | 1 selects send-on-release behaviour |
| press_stb | input | 1 | Key press strobe |
| release_stb | input | 1 | Key release strobe |
| ir_out | output | 1 | LED drive level, idles low |
| busy | output | 1 | High while a burst pair is in progress |

## Verification
Suppose a strobe is accepted at rising edge k. Then `busy` is due one cycle later, at edge k+1, while `ir_out` stays low until the first `chip_tick` edge after that. From then on, each output level appears right after the tick edge that starts its chip or gap interval, and `busy` falls after the tick edge that closes the final chip. The bench advances a queue-based reference model on the same rising edge the design samples and compares both outputs at every falling edge. As a result, every expected change is checked in the first cycle it becomes visible.

// File: rtl/ir_clicker_tx.sv
module ir_clicker_tx #(
  parameter int CODE_W     = 4,
  parameter int ID_W       = 24,
  parameter int SUM_W      = 8,
  parameter int CHIP_TICKS = 4,
  parameter int GAP_TICKS  = 73
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_tick,
  input  logic [CODE_W-1:0] btn_code,
  input  logic [ID_W-1:0]   tx_id,
  input  logic              key_star,
  input  logic              press_stb,
  input  logic              release_stb,
  output logic              ir_out,
  output logic              busy
);
  localparam int PKT_W = CODE_W + ID_W + SUM_W;
  localparam int BW    = $clog2(PKT_W);
  localparam int TW    = $clog2(CHIP_TICKS + 1);
  localparam int GW    = $clog2(GAP_TICKS + 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(PKT_W - 1);
  localparam logic [TW-1:0] LAST_T   = TW'(CHIP_TICKS - 1);
  localparam logic [GW-1:0] LAST_G   = GW'(GAP_TICKS - 1);

  typedef enum logic [1:0] {IDLE, ARM, SEND, GAP} st_t;

  st_t              st;
  logic [PKT_W-1:0] pkt;
  logic [BW-1:0]    bit_i;
  logic [1:0]       phase;
  logic [TW-1:0]    tcnt;
  logic [GW-1:0]    gcnt;
  logic             second;
  logic [SUM_W-1:0] csum;

  always_comb begin
    csum = SUM_W'(btn_code);
    for (int i = 0; i < ID_W / 8; i++)
      csum = csum + SUM_W'(tx_id[i*8 +: 8]);
  end

  wire start     = (st == IDLE) && (key_star ? release_stb : press_stb);
  wire chip_end  = chip_tick && (tcnt == LAST_T);
  wire data_chip = pkt[LAST_BIT - bit_i] ^ second;

  assign busy   = (st != IDLE);
  assign ir_out = (st == SEND) && ((phase == 2'd1) || (phase == 2'd2 && data_chip));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      pkt    <= '0;
      bit_i  <= '0;
      phase  <= '0;
      tcnt   <= '0;
      gcnt   <= '0;
      second <= 1'b0;
    end else begin
      case (st)
        IDLE: if (start) begin
          pkt    <= {btn_code, tx_id, csum};
          second <= 1'b0;
          st     <= ARM;
        end
        ARM: if (chip_tick) begin
          st    <= SEND;
          tcnt  <= '0;
          phase <= '0;
          bit_i <= '0;
        end
        SEND: if (chip_tick) begin
          if (!chip_end) tcnt <= tcnt + 1'b1;
          else begin
            tcnt <= '0;
            if (phase != 2'd2) phase <= phase + 2'd1;
            else begin
              phase <= '0;
              if (bit_i != LAST_BIT) bit_i <= bit_i + 1'b1;
              else begin
                bit_i <= '0;
                if (second) st <= IDLE;
                else begin
                  st   <= GAP;
                  gcnt <= '0;
                end
              end
            end
          end
        end
        GAP: if (chip_tick) begin
          if (gcnt == LAST_G) begin
            st     <= SEND;
            second <= 1'b1;
            tcnt   <= '0;
            phase  <= '0;
          end else gcnt <= gcnt + 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ir_clicker_chk.sv
module ir_clicker_chk (
  input logic clk,
  input logic rst_n,
  input logic chip_tick,
  input logic key_star,
  input logic press_stb,
  input logic release_stb,
  input logic ir_out,
  input logic busy
);
  assert_dark_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ir_out);

  assert_edges_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_tick |=> $stable(ir_out));

  assert_letter_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && press_stb && !key_star) |=> busy);

  assert_letter_release_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && release_stb && !press_stb && !key_star) |=> !busy);

  assert_star_press_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && press_stb && !release_stb && key_star) |=> !busy);

  assert_star_release_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && release_stb && key_star) |=> busy);

  assert_busy_ends_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(chip_tick));
endmodule

bind ir_clicker_tx ir_clicker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .chip_tick(chip_tick), .key_star(key_star),
  .press_stb(press_stb), .release_stb(release_stb), .ir_out(ir_out), .busy(busy)
);

// File: tb/tb_ir_clicker_tx.sv
module tb_ir_clicker_tx;
  localparam int CT  = 2;
  localparam int GT  = 5;
  localparam int DIV = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chip_tick = 1'b0;
  logic [3:0]  btn_code = '0;
  logic [23:0] tx_id = '0;
  logic        key_star = 1'b0;
  logic        press_stb = 1'b0;
  logic        release_stb = 1'b0;
  logic        ir_out;
  logic        busy;

  ir_clicker_tx #(.CHIP_TICKS(CT), .GAP_TICKS(GT)) dut (
    .clk(clk), .rst_n(rst_n), .chip_tick(chip_tick), .btn_code(btn_code),
    .tx_id(tx_id), .key_star(key_star), .press_stb(press_stb),
    .release_stb(release_stb), .ir_out(ir_out), .busy(busy)
  );

  always #10 clk = ~clk;

  int    compared = 0;
  int    mismatched = 0;
  int    cyc = 0;
  int    tdiv = 0;
  string tag = "R1";
  bit    m_busy = 0;
  bit    m_out = 0;
  bit    q[$];

  function automatic int ref_sum(input int code, input int id);
    int s = code;
    for (int k = 0; k < 3; k++) s += (id >> (8 * k)) & 255;
    return s % 256;
  endfunction

  task automatic fill(input int code, input int id);
    bit [35:0] p;
    p = {code[3:0], id[23:0], 8'(ref_sum(code, id))};
    q.delete();
    for (int b = 0; b < 2; b++) begin
      for (int i = 35; i >= 0; i--) begin
        repeat (CT) q.push_back(1'b0);
        repeat (CT) q.push_back(1'b1);
        repeat (CT) q.push_back(p[i] ^ b[0]);
      end
      if (b == 0) repeat (GT) q.push_back(1'b0);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_out = 0; q.delete();
    end else if (!m_busy) begin
      if (key_star ? release_stb : press_stb) begin
        m_busy = 1; m_out = 0;
        fill(int'(btn_code), int'(tx_id));
      end
    end else if (chip_tick) begin
      if (q.size() == 0) begin
        m_busy = 0; m_out = 0;
      end else m_out = q.pop_front();
    end
  end

  always @(negedge clk) begin
    tdiv = (tdiv + 1) % DIV;
    chip_tick <= (tdiv == 0);
  end

  always @(negedge clk) begin
    cyc++;
    compared++;
    if (busy !== m_busy || ir_out !== m_out) begin
      mismatched++;
      $display("FAIL %s cycle %0d: busy=%b ir_out=%b expected busy=%b ir_out=%b",
               tag, cyc, busy, ir_out, m_busy, m_out);
    end
    if (cyc > 150000) begin
      mismatched++;
      $display("FAIL R9 watchdog: actual still running, expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic strobe(input bit pr, input bit rl);
    @(negedge clk);
    press_stb <= pr; release_stb <= rl;
    @(negedge clk);
    press_stb <= 0; release_stb <= 0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (m_busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    tag = "R1";
    repeat (5) @(negedge clk);
    rst_n <= 1;
    repeat (5) @(negedge clk);

    tag = "R2 R3 R4 R5 R6 R7";
    btn_code <= 4'b1001; tx_id <= 24'h00D915; key_star <= 0;
    strobe(1, 0);
    wait_done();

    tag = "R3 R5 R7";
    btn_code <= 4'b1100; tx_id <= 24'hABCDEF;
    strobe(1, 1);
    wait_done();

    tag = "R7";
    btn_code <= 4'b1010; tx_id <= 24'h123456;
    strobe(0, 1);
    repeat (20) @(negedge clk);
    strobe(1, 0);
    wait_done();

    tag = "R8";
    key_star <= 1; btn_code <= 4'b1111; tx_id <= 24'hFFFFFF;
    strobe(1, 0);
    repeat (20) @(negedge clk);
    strobe(0, 1);
    wait_done();

    tag = "R9";
    key_star <= 0; btn_code <= 4'b1101; tx_id <= 24'h5A5A00;
    strobe(1, 0);
    repeat (50) @(negedge clk);
    btn_code <= 4'b1110; tx_id <= 24'h000001;
    strobe(1, 1);
    repeat (300) @(negedge clk);
    key_star <= 1;
    strobe(0, 1);
    key_star <= 0;
    wait_done();

    tag = "R4 R1";
    @(negedge clk);
    while (chip_tick !== 1'b1) @(negedge clk);
    btn_code <= 4'b1011; tx_id <= 24'h800000;
    press_stb <= 1;
    @(negedge clk);
    press_stb <= 0;
    wait_done();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule